// File: doc/BRIEF.md
# Watchdog Timer with Keyed Feed

A bus-mapped watchdog. Software programs a reload value, sets an enable bit and then keeps the block alive by writing a two-byte key pair to a feed register. A prescaler divides the block clock by a fixed factor, and each prescaler tick decrements a down-counter. A correct key pair reloads the counter. If the counter drains to zero, a sticky timeout flag is raised. When reset generation has been armed, a reset request is also raised and held.

The block does not start counting when it is enabled. It starts at the first correct key pair after enable. From then on it cannot be stopped by any register write. If software writes the first key and then writes a wrong second value to the feed register, the block issues a reset request at once. Software can use this as a deliberate reboot path. Bus and watchdog logic share one clock. Only writes count as bus accesses.

Top module: `wdt_feedseq`

## Requirements
- R1: After reset the control register (byte offset 0x0) reads 0, the reload register (0x4) reads 0xFF, the count register (0xC) reads 0xFF, and `rst_req` is low.
- R2: Control register bit 0 is enable and bit 1 is reset-arm. Both bits can only be set: writing 0 leaves them at 1. Bit 2 is the read-only sticky timeout flag.
- R3: A reload write below 0xFF stores 0xFF. A write above 0xFFFFFF stores 0xFFFFFF. Any other value is stored unchanged.
- R4: Setting enable alone does not start counting. While the block is not running, the count holds its value.
- R5: A correct feed is a write of 0xAA to the feed register (0x8) followed directly by a write of 0x55 to it. It loads the reload value into the count. If enable is set, it also starts the block.
- R6: While running, the count drops by one every 4 clocks. The first drop happens on the 4th clock after the feed.
- R7: When the running count reaches 0, the timeout flag sets and the count stays at 0. If reset-arm is set, `rst_req` rises on that same edge and stays high until the block is reset, even if a later feed arrives.
- R8: An expiry with reset-arm clear sets the timeout flag but leaves `rst_req` low.
- R9: While the block is running with reset-arm set, a write of 0xAA to the feed register followed directly by a feed write other than 0x55 raises `rst_req` on that second write.
- R10: A write to any other register between 0xAA and 0x55 cancels the sequence. The 0x55 that follows then does not reload the count.
- R11: A wrong second key while the block is not running leaves `rst_req` low.
- R12: A feed write of any value other than 0xAA, when no sequence is pending, has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, shared by the bus and the counter |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| rst_req | output | 1 | Sticky reset request |

## Verification
Register writes take effect on the clock edge of their strobe. Reads are combinational, so the bench samples the value on the falling edge after the write.

A correct feed reloads the count on the edge of the 0x55 write. The count then drops on every 4th edge after that, so after n further edges it equals the reload value minus n/4, rounded down. The bench counts falling edges from the feed and samples one edge either side of each decrement and of expiry: for a reload of 0xFF, expiry falls on edge 1020.

A wrong second key raises `rst_req` on the edge of the second write itself. The bench therefore checks it directly after that write, and also checks that it was still low after the first key.

// File: rtl/wdt_feedseq.sv
module wdt_feedseq #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 24,
  parameter int PRESCALE = 4,
  parameter int TC_MIN   = 'hFF,
  parameter logic [7:0] KEY_A = 8'hAA,
  parameter logic [7:0] KEY_B = 8'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req
);
  localparam int PS_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PS_W-1:0]   PS_LAST = PS_W'(PRESCALE - 1);
  localparam logic [CNT_W-1:0]  CNT_MIN = CNT_W'(TC_MIN);
  localparam logic [CNT_W-1:0]  CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0]  CNT_ONE = CNT_W'(1);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_RELD  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_FEED  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(12);

  logic             en_q, rsten_q, tof_q, run_q, armed_q;
  logic [CNT_W-1:0] tc_q, cnt_q;
  logic [PS_W-1:0]  ps_q;

  wire feed_wr  = bus_we && (bus_addr == A_FEED);
  wire good     = feed_wr && armed_q && (bus_wdata[7:0] == KEY_B);
  wire bad      = feed_wr && armed_q && (bus_wdata[7:0] != KEY_B);
  wire tick     = run_q && (ps_q == PS_LAST);
  wire expire   = tick && (cnt_q == CNT_ONE);
  wire [CNT_W-1:0] tc_in =
    (bus_wdata < DATA_W'(CNT_MIN)) ? CNT_MIN :
    (bus_wdata > DATA_W'(CNT_MAX)) ? CNT_MAX : bus_wdata[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      rsten_q <= 1'b0;
    end else if (bus_we && bus_addr == A_CTRL) begin
      en_q    <= en_q    | bus_wdata[0];
      rsten_q <= rsten_q | bus_wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               tc_q <= CNT_MIN;
    else if (bus_we && bus_addr == A_RELD)    tc_q <= tc_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed_q <= 1'b0;
    else if (bus_we) armed_q <= feed_wr && !armed_q && (bus_wdata[7:0] == KEY_A);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           run_q <= 1'b0;
    else if (good && en_q) run_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ps_q <= '0;
    else if (good || !run_q) ps_q <= '0;
    else                     ps_q <= (ps_q == PS_LAST) ? '0 : ps_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= CNT_MIN;
    else if (good)                  cnt_q <= tc_q;
    else if (tick && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tof_q   <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (expire) tof_q <= 1'b1;
      if (rsten_q && (expire || (bad && run_q))) rst_req <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata = DATA_W'({tof_q, rsten_q, en_q});
      A_RELD:  bus_rdata = DATA_W'(tc_q);
      A_CNT:   bus_rdata = DATA_W'(cnt_q);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdt_feedseq_chk.sv
module wdt_feedseq_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24,
  parameter int TC_MIN = 'hFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rst_req,
  input logic              en_q,
  input logic              rsten_q,
  input logic              run_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  tc_q
);
  wire feed_wr = bus_we && (bus_addr == ADDR_W'(8));
  wire low_tc  = bus_we && (bus_addr == ADDR_W'(4)) && (bus_wdata < DATA_W'(TC_MIN));

  p_en_setonly_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);
  p_arm_setonly_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsten_q |=> rsten_q);
  p_tc_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    low_tc |=> (tc_q == CNT_W'(TC_MIN)));
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !feed_wr) |=> $stable(cnt_q));
  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !feed_wr) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 1'b1));
  p_req_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);
  p_req_needs_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !rst_req) |=> !rst_req);
endmodule

bind wdt_feedseq wdt_feedseq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .TC_MIN(TC_MIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .rst_req(rst_req), .en_q(en_q), .rsten_q(rsten_q),
  .run_q(run_q), .cnt_q(cnt_q), .tc_q(tc_q)
);

// File: tb/wdt_feedseq_tb.sv
module wdt_feedseq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_req;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdt_feedseq u_dut (.clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr),
                     .bus_wdata(wdata), .bus_rdata(rdata), .rst_req(rst_req));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    addr = a; #0.5; v = rdata;
  endtask

  task automatic feed();
    wr(4'h8, 32'hAA); wr(4'h8, 32'h55);
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    waitc(3); rst_n = 1'b1; waitc(1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    rd(4'h0, v); check("R1 ctrl", v, 0);
    rd(4'h4, v); check("R1 reload", v, 32'hFF);
    rd(4'hC, v); check("R1 count", v, 32'hFF);
    check("R1 rst_req", rst_req, 0);
  endtask

  task automatic t_setonly();
    logic [31:0] v;
    do_reset();
    wr(4'h0, 32'h3); wr(4'h0, 32'h0);
    rd(4'h0, v); check("R2 set-only bits", v, 32'h3);
    waitc(20);
    rd(4'hC, v); check("R4 enable alone holds count", v, 32'hFF);
  endtask

  task automatic t_clamp();
    logic [31:0] v;
    do_reset();
    wr(4'h4, 32'h10);       rd(4'h4, v); check("R3 floor", v, 32'hFF);
    wr(4'h4, 32'h1234);     rd(4'h4, v); check("R3 in range", v, 32'h1234);
    wr(4'h4, 32'hFFABCDEF); rd(4'h4, v); check("R3 ceiling", v, 32'hFFFFFF);
  endtask

  task automatic t_sequence();
    logic [31:0] v;
    do_reset();
    wr(4'h4, 32'h300);
    wr(4'h8, 32'h55);
    rd(4'hC, v); check("R12 lone 0x55 ignored", v, 32'hFF);
    wr(4'h8, 32'h12); wr(4'h8, 32'h55);
    rd(4'hC, v); check("R12 non-key ignored", v, 32'hFF);
    wr(4'h8, 32'hAA); wr(4'h4, 32'h400); wr(4'h8, 32'h55);
    rd(4'hC, v); check("R10 abort", v, 32'hFF);
    feed();
    rd(4'hC, v); check("R5 reload", v, 32'h400);
    waitc(20);
    rd(4'hC, v); check("R4 not enabled holds", v, 32'h400);
  endtask

  task automatic t_countdown();
    logic [31:0] v;
    do_reset();
    wr(4'h4, 32'h120); wr(4'h0, 32'h1); feed();
    rd(4'hC, v); check("R5 reload on start", v, 32'h120);
    waitc(3);  rd(4'hC, v); check("R6 before first tick", v, 32'h120);
    waitc(1);  rd(4'hC, v); check("R6 first tick", v, 32'h11F);
    waitc(7);  rd(4'hC, v); check("R6 edge 11", v, 32'h11E);
    waitc(1);  rd(4'hC, v); check("R6 edge 12", v, 32'h11D);
    feed();    rd(4'hC, v); check("R5 refeed", v, 32'h120);
    wr(4'h8, 32'hAA); wr(4'h8, 32'h13);
    check("R9 bad key without arm", rst_req, 0);
  endtask

  task automatic t_expire_arm();
    logic [31:0] v;
    do_reset();
    wr(4'h0, 32'h3); feed();
    waitc(1019);
    rd(4'hC, v); check("R7 one before expiry", v, 32'h1);
    check("R7 no request yet", rst_req, 0);
    waitc(1);
    rd(4'hC, v); check("R7 count zero", v, 32'h0);
    check("R7 request", rst_req, 1);
    rd(4'h0, v); check("R7 flag", v, 32'h7);
    waitc(10);
    rd(4'hC, v); check("R7 count holds zero", v, 32'h0);
    wr(4'h0, 32'h0); rd(4'h0, v); check("R2 no clear", v, 32'h7);
    feed();
    check("R7 request held after feed", rst_req, 1);
  endtask

  task automatic t_expire_noarm();
    logic [31:0] v;
    do_reset();
    wr(4'h0, 32'h1); feed();
    waitc(1021);
    rd(4'h0, v); check("R8 flag only", v, 32'h5);
    check("R8 no request", rst_req, 0);
  endtask

  task automatic t_bad_feed();
    do_reset();
    wr(4'h0, 32'h3); feed();
    wr(4'h8, 32'hAA);
    check("R9 after first key", rst_req, 0);
    wr(4'h8, 32'hAA);
    check("R9 wrong second key", rst_req, 1);
    do_reset();
    wr(4'h0, 32'h2); wr(4'h8, 32'hAA); wr(4'h8, 32'h00);
    check("R11 not enabled", rst_req, 0);
    wr(4'h0, 32'h1); wr(4'h8, 32'hAA); wr(4'h8, 32'h11);
    waitc(2);
    check("R11 enabled, not running", rst_req, 0);
  endtask

  initial begin
    t_reset();
    t_setonly();
    t_clamp();
    t_sequence();
    t_countdown();
    t_expire_arm();
    t_expire_noarm();
    t_bad_feed();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule